// File: doc/BRIEF.md
# Time-Shared Multiplier Biquad Section

This block is one second-order recursive filter section in direct form 1. It holds the two previous input samples and the two previous output samples. When a strobe arrives with a new signed sample, it evaluates the five-term difference equation. A single signed multiplier serves every coefficient product. A small sequencer feeds that multiplier one tap per clock and adds or subtracts each product in a wide accumulator. The sum is then shifted down by the coefficient fraction width, clamped to the sample range, and fed back into the history. A build-time switch can add one more multiplier pass for an output gain. The output sample and its one-cycle strobe come straight from flip-flops.

The six coefficients are static input ports in two's complement with `W_FRAC` fraction bits. A coefficient value of 1.0 is therefore `2**W_FRAC`. The surrounding logic must keep the coefficients steady while a sample is being processed. It must also space input strobes at least `LATENCY+1` cycles apart, where `LATENCY = 6 + GAIN_EN`.

Top module: `biquad_shared_mul`

## Requirements
- R1: A synchronous active-high `rst` clears `out_data` to 0, `out_stb` to 0, all four history registers, the accumulator and the sequencer. The first sample accepted after reset therefore gives y = sat((b0*x) >>> W_FRAC).
- R2: With the gain disabled, each result is y[n] = sat((b0*x[n] + b1*x[n-1] + b2*x[n-2] - a1*y[n-1] - a2*y[n-2]) >>> W_FRAC). All values are two's complement. The sum is exact, and the shift is arithmetic, so it rounds toward minus infinity.
- R3: The two feedback products (a1 with y[n-1], a2 with y[n-2]) are subtracted, not added. The stored y values are the clamped results before any output gain.
- R4: The shifted sum is clamped to the signed range of `W_DAT` bits, from -2**(W_DAT-1) to 2**(W_DAT-1)-1, before it is stored and driven out. The gain result is clamped to the same range.
- R5: `out_stb` is high for exactly one cycle. It rises `LATENCY = 6 + GAIN_EN` rising edges after the edge that samples an accepted `in_stb`.
- R6: With `GAIN_EN = 1`, `out_data` = sat((y[n]*g) >>> W_FRAC). The history still takes the ungained y[n].
- R7: A strobe is ignored if it is sampled on any edge from the accepting edge up to and including the edge that raises `out_stb`. An ignored strobe produces no output pulse and leaves the history unchanged.
- R8: `out_data` changes only in a cycle where `out_stb` is high. Between strobes it holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | W_DAT | Signed input sample |
| in_stb | input | 1 | Marks a new sample on `in_data` |
| coef_b0 | input | W_COEF | Feed-forward coefficient for x[n] |
| coef_b1 | input | W_COEF | Feed-forward coefficient for x[n-1] |
| coef_b2 | input | W_COEF | Feed-forward coefficient for x[n-2] |
| coef_a1 | input | W_COEF | Feedback coefficient for y[n-1] (subtracted) |
| coef_a2 | input | W_COEF | Feedback coefficient for y[n-2] (subtracted) |
| coef_g | input | W_COEF | Output gain, used only when GAIN_EN = 1 |
| out_data | output | W_DAT | Signed result, meaningful when `out_stb` is high |
| out_stb | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that reset is held for at least two clock edges. They also assume that any strobe arriving while the section is busy is one the design must drop. Their reference window starts at an accepted strobe and runs for exactly `LATENCY` edges. The stimulus raises each real strobe for a single cycle and changes coefficients only while both instances are idle. Extra strobes appear only in the busy test, and only inside the busy window. Two instances with the gain on and off see the same inputs, and both are compared with a fixed-point model of the recursion.

// File: rtl/bq_pkg.sv
package bq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MAC,
    ST_FIN,
    ST_GAIN
  } bq_state_t;

  // five taps: 0..2 feed-forward, 3..4 feedback
  localparam int unsigned NUM_TAPS     = 5;
  localparam int unsigned TAP_W        = $clog2(NUM_TAPS);
  localparam int unsigned FIRST_FB_TAP = 3;
  // edges from accept to result without the gain pass
  localparam int unsigned BASE_LAT     = NUM_TAPS + 1;
endpackage

// File: rtl/bq_ctrl.sv
module bq_ctrl
  import bq_pkg::*;
#(
  parameter bit GAIN_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_stb,
  output bq_state_t        state,
  output logic [TAP_W-1:0] tap,
  output logic             accept
);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

  bq_state_t        state_q, state_d;
  logic [TAP_W-1:0] tap_q, tap_d;

  assign accept = (state_q == ST_IDLE) && in_stb;

  always_comb begin
    state_d = state_q;
    tap_d   = tap_q;
    unique case (state_q)
      ST_IDLE: begin
        tap_d = '0;
        if (in_stb) state_d = ST_MAC;
      end
      ST_MAC: begin
        if (tap_q == LAST_TAP) begin
          state_d = ST_FIN;
          tap_d   = '0;
        end else begin
          tap_d = tap_q + 1'b1;
        end
      end
      ST_FIN:  state_d = GAIN_EN ? ST_GAIN : ST_IDLE;
      ST_GAIN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
    end else begin
      state_q <= state_d;
      tap_q   <= tap_d;
    end
  end

  assign state = state_q;
  assign tap   = tap_q;
endmodule

// File: rtl/bq_hist.sv
module bq_hist #(
  parameter int unsigned W_DAT = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic signed [W_DAT-1:0] x_in,
  input  logic                    shift,
  input  logic signed [W_DAT-1:0] y_in,
  output logic signed [W_DAT-1:0] x0,
  output logic signed [W_DAT-1:0] x1,
  output logic signed [W_DAT-1:0] x2,
  output logic signed [W_DAT-1:0] y1,
  output logic signed [W_DAT-1:0] y2
);
  // current input sample, captured on accept
  always_ff @(posedge clk) begin
    if (rst)       x0 <= '0;
    else if (load) x0 <= x_in;
  end

  // delay line advances once per completed sample
  always_ff @(posedge clk) begin
    if (rst) begin
      x1 <= '0;
      x2 <= '0;
      y1 <= '0;
      y2 <= '0;
    end else if (shift) begin
      x2 <= x1;
      x1 <= x0;
      y2 <= y1;
      y1 <= y_in;
    end
  end
endmodule

// File: rtl/bq_mac.sv
module bq_mac #(
  parameter int unsigned W_DAT  = 16,
  parameter int unsigned W_COEF = 16,
  parameter int unsigned W_FRAC = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     acc_en,
  input  logic                     sub,
  input  logic signed [W_COEF-1:0] coef_op,
  input  logic signed [W_DAT-1:0]  data_op,
  output logic signed [W_DAT-1:0]  acc_sat,
  output logic signed [W_DAT-1:0]  prod_sat
);
  localparam int unsigned PROD_W = W_DAT + W_COEF;
  localparam int unsigned ACC_W  = PROD_W + 3;

  localparam logic signed [ACC_W-1:0] SAT_HI =
    {{(ACC_W-W_DAT+1){1'b0}}, {(W_DAT-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO =
    {{(ACC_W-W_DAT+1){1'b1}}, {(W_DAT-1){1'b0}}};

  function automatic logic signed [W_DAT-1:0] clamp(input logic signed [ACC_W-1:0] v);
    if (v > SAT_HI)      clamp = SAT_HI[W_DAT-1:0];
    else if (v < SAT_LO) clamp = SAT_LO[W_DAT-1:0];
    else                 clamp = v[W_DAT-1:0];
  endfunction

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_x;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  acc_sh;
  logic signed [ACC_W-1:0]  prod_sh;

  // the one shared multiplier
  assign prod   = coef_op * data_op;
  assign prod_x = ACC_W'(prod);

  always_ff @(posedge clk) begin
    if (rst || clr)  acc_q <= '0;
    else if (acc_en) acc_q <= sub ? (acc_q - prod_x) : (acc_q + prod_x);
  end

  assign acc_sh   = acc_q >>> W_FRAC;
  assign prod_sh  = prod_x >>> W_FRAC;
  assign acc_sat  = clamp(acc_sh);
  assign prod_sat = clamp(prod_sh);
endmodule

// File: rtl/biquad_shared_mul.sv
module biquad_shared_mul
  import bq_pkg::*;
#(
  parameter int unsigned W_DAT   = 16,
  parameter int unsigned W_COEF  = 16,
  parameter int unsigned W_FRAC  = 14,
  parameter bit          GAIN_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [W_DAT-1:0]  in_data,
  input  logic                     in_stb,
  input  logic signed [W_COEF-1:0] coef_b0,
  input  logic signed [W_COEF-1:0] coef_b1,
  input  logic signed [W_COEF-1:0] coef_b2,
  input  logic signed [W_COEF-1:0] coef_a1,
  input  logic signed [W_COEF-1:0] coef_a2,
  input  logic signed [W_COEF-1:0] coef_g,
  output logic signed [W_DAT-1:0]  out_data,
  output logic                     out_stb
);
  localparam int unsigned LATENCY = BASE_LAT + (GAIN_EN ? 1 : 0);

  bq_state_t               state;
  logic [TAP_W-1:0]        tap;
  logic                    accept;
  logic signed [W_DAT-1:0] x0, x1, x2, y1, y2;
  logic signed [W_COEF-1:0] coef_op;
  logic signed [W_DAT-1:0] data_op;
  logic signed [W_DAT-1:0] acc_sat, prod_sat;
  logic                    fin_step;

  assign fin_step = (state == ST_FIN);

  bq_ctrl #(.GAIN_EN(GAIN_EN)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .in_stb (in_stb),
    .state  (state),
    .tap    (tap),
    .accept (accept)
  );

  bq_hist #(.W_DAT(W_DAT)) u_hist (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .x_in  (in_data),
    .shift (fin_step),
    .y_in  (acc_sat),
    .x0    (x0),
    .x1    (x1),
    .x2    (x2),
    .y1    (y1),
    .y2    (y2)
  );

  // operand select for the shared multiplier; the gain pass reuses y1,
  // which already holds the fresh result after the finish step
  always_comb begin
    coef_op = '0;
    data_op = '0;
    if (GAIN_EN && state == ST_GAIN) begin
      coef_op = coef_g;
      data_op = y1;
    end else begin
      case (tap)
        TAP_W'(0): begin coef_op = coef_b0; data_op = x0; end
        TAP_W'(1): begin coef_op = coef_b1; data_op = x1; end
        TAP_W'(2): begin coef_op = coef_b2; data_op = x2; end
        TAP_W'(3): begin coef_op = coef_a1; data_op = y1; end
        TAP_W'(4): begin coef_op = coef_a2; data_op = y2; end
        default:   begin coef_op = '0;      data_op = '0; end
      endcase
    end
  end

  bq_mac #(.W_DAT(W_DAT), .W_COEF(W_COEF), .W_FRAC(W_FRAC)) u_mac (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .acc_en   (state == ST_MAC),
    .sub      (tap >= TAP_W'(FIRST_FB_TAP)),
    .coef_op  (coef_op),
    .data_op  (data_op),
    .acc_sat  (acc_sat),
    .prod_sat (prod_sat)
  );

  generate
    if (GAIN_EN) begin : g_gain
      always_ff @(posedge clk) begin
        if (rst) begin
          out_data <= '0;
          out_stb  <= 1'b0;
        end else begin
          out_stb <= (state == ST_GAIN);
          if (state == ST_GAIN) out_data <= prod_sat;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) begin
          out_data <= '0;
          out_stb  <= 1'b0;
        end else begin
          out_stb <= fin_step;
          if (fin_step) out_data <= acc_sat;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bq_chk.sv
module bq_chk #(
  parameter int unsigned W_DAT   = 16,
  parameter bit          GAIN_EN = 1'b1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_stb,
  input logic                    out_stb,
  input logic signed [W_DAT-1:0] out_data
);
  localparam int unsigned LAT = 6 + (GAIN_EN ? 1 : 0);

  logic [3:0] win;
  logic       rst_q;

  // window counter: 1..LAT while a sample is in flight
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)                 win <= '0;
    else if (win == 4'd0)    win <= in_stb ? 4'd1 : 4'd0;
    else if (win == 4'(LAT)) win <= '0;
    else                     win <= win + 4'd1;
  end

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (out_data == '0 && !out_stb));

  a_r5_strobe_on_time: assert property (@(posedge clk) disable iff (rst)
    (win == 4'(LAT)) |=> out_stb);

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
    out_stb |=> !out_stb);

  a_r7_no_stray_strobe: assert property (@(posedge clk) disable iff (rst)
    (win != 4'(LAT)) |=> !out_stb);

  a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
    !out_stb |-> $stable(out_data));
endmodule

bind biquad_shared_mul bq_chk #(.W_DAT(W_DAT), .GAIN_EN(GAIN_EN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_stb   (in_stb),
  .out_stb  (out_stb),
  .out_data (out_data)
);

// File: tb/sim_biquad_shared_mul.sv
module sim_biquad_shared_mul;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;
  localparam int W_DAT  = 16;
  localparam int W_COEF = 16;
  localparam int W_FRAC = 14;
  localparam longint MAXV = 32767;
  localparam longint MINV = -32768;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [W_DAT-1:0]  in_data = '0;
  logic                     in_stb  = 1'b0;
  logic signed [W_COEF-1:0] cb0 = '0, cb1 = '0, cb2 = '0, ca1 = '0, ca2 = '0, cg = '0;
  logic signed [W_DAT-1:0]  o0_data, o1_data;
  logic                     o0_stb, o1_stb;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  longint mx1, mx2, my1, my2;
  longint last0, last1;

  always #(CLK_PERIOD/2) clk = ~clk;

  // gain enabled
  biquad_shared_mul #(.W_DAT(W_DAT), .W_COEF(W_COEF), .W_FRAC(W_FRAC), .GAIN_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_stb(in_stb),
    .coef_b0(cb0), .coef_b1(cb1), .coef_b2(cb2), .coef_a1(ca1), .coef_a2(ca2), .coef_g(cg),
    .out_data(o0_data), .out_stb(o0_stb));

  // gain disabled
  biquad_shared_mul #(.W_DAT(W_DAT), .W_COEF(W_COEF), .W_FRAC(W_FRAC), .GAIN_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_stb(in_stb),
    .coef_b0(cb0), .coef_b1(cb1), .coef_b2(cb2), .coef_a1(ca1), .coef_a2(ca2), .coef_g(cg),
    .out_data(o1_data), .out_stb(o1_stb));

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint clampv(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic model_clear();
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    last0 = 0; last1 = 0;
  endtask

  task automatic model_step(input longint x, output longint y_plain, output longint y_gain);
    longint acc;
    acc = longint'(cb0) * x + longint'(cb1) * mx1 + longint'(cb2) * mx2
        - longint'(ca1) * my1 - longint'(ca2) * my2;
    y_plain = clampv(acc >>> W_FRAC);
    y_gain  = clampv((y_plain * longint'(cg)) >>> W_FRAC);
    mx2 = mx1; mx1 = x; my2 = my1; my1 = y_plain;
  endtask

  // one sample; checks strobe timing, data and hold on both instances
  task automatic send(input logic signed [W_DAT-1:0] x, input string dtag, input bit noise);
    longint yp, yg;
    string stag;
    model_step(longint'(x), yp, yg);
    stag = noise ? "R7" : "R5";
    @(negedge clk); in_data = x; in_stb = 1'b1;
    @(negedge clk); in_stb = 1'b0;
    for (int k = 0; k <= 8; k++) begin
      check(stag, "plain strobe", longint'(o1_stb), longint'(k == 6));
      check(stag, "gain strobe",  longint'(o0_stb), longint'(k == 7));
      if (o1_stb) begin
        check(dtag, "plain data", longint'(o1_data), yp);
        last1 = yp;
      end else begin
        check("R8", "plain hold", longint'(o1_data), last1);
      end
      if (o0_stb) begin
        check((dtag == "R2") ? "R6" : dtag, "gain data", longint'(o0_data), yg);
        last0 = yg;
      end else begin
        check("R8", "gain hold", longint'(o0_data), last0);
      end
      if (noise && k <= 3) begin in_stb = 1'b1; in_data = ~x; end
      else                 begin in_stb = 1'b0; end
      if (k < 8) @(negedge clk);
    end
    in_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    check("R1", "plain data after reset", longint'(o1_data), 0);
    check("R1", "plain strobe after reset", longint'(o1_stb), 0);
    check("R1", "gain data after reset", longint'(o0_data), 0);
    check("R1", "gain strobe after reset", longint'(o0_stb), 0);
  endtask

  task automatic t_reset_history();
    cb0 = 16'sd8192; cb1 = 16'sd12000; cb2 = -16'sd5000;
    ca1 = 16'sd3000; ca2 = -16'sd2000; cg = 16'sd16384;
    send(16'sd1000, "R2", 1'b0);
    send(16'sd2000, "R2", 1'b0);
    do_reset();
    // only b0 contributes on the first sample after reset
    send(16'sd4000, "R1", 1'b0);
  endtask

  task automatic t_impulse();
    do_reset();
    cb0 = 16'sd4096; cb1 = 16'sd8192; cb2 = 16'sd4096;
    ca1 = -16'sd20000; ca2 = 16'sd8000; cg = 16'sd24576;
    send(16'sd8000, "R3", 1'b0);
    for (int i = 0; i < 10; i++) send(16'sd0, "R3", 1'b0);
  endtask

  task automatic t_step();
    do_reset();
    cb0 = 16'sd2000; cb1 = 16'sd4000; cb2 = 16'sd2000;
    ca1 = -16'sd24000; ca2 = 16'sd9500; cg = 16'sd12000;
    for (int i = 0; i < 12; i++) send(16'sd5000, "R2", 1'b0);
    for (int i = 0; i < 6; i++) send(-16'sd3001, "R2", 1'b0);
  endtask

  task automatic t_saturate();
    do_reset();
    cb0 = 16'sd32767; cb1 = 16'sd32767; cb2 = 16'sd32767;
    ca1 = 16'sd0; ca2 = 16'sd0; cg = 16'sd30000;
    for (int i = 0; i < 3; i++) send(16'sd32767, "R4", 1'b0);
    for (int i = 0; i < 3; i++) send(-16'sd32768, "R4", 1'b0);
    send(16'sd7, "R4", 1'b0);
  endtask

  task automatic t_busy();
    do_reset();
    cb0 = 16'sd9000; cb1 = -16'sd7000; cb2 = 16'sd3000;
    ca1 = -16'sd10000; ca2 = 16'sd4000; cg = -16'sd20000;
    send(16'sd1234, "R7", 1'b1);
    send(-16'sd4321, "R7", 1'b1);
    // clean samples reveal whether ignored strobes touched the history
    send(16'sd777, "R7", 1'b0);
    send(16'sd0, "R7", 1'b0);
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 40; i++) begin
      if (i % 8 == 0) begin
        cb0 = 16'($urandom); cb1 = 16'($urandom); cb2 = 16'($urandom);
        ca1 = 16'($urandom); ca2 = 16'($urandom); cg = 16'($urandom);
      end
      send(16'($urandom), "R2", 1'b0);
    end
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    model_clear();
    do_reset();
    t_reset_history();
    t_impulse();
    t_step();
    t_saturate();
    t_busy();
    t_random();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule